// File: doc/BRIEF.md
# Interrupt Source Pending Controller

This block gathers up to 32 already-synchronised interrupt request lines into a register of pending flags. It combines that register with a per-source mask to drive one interrupt request line to the processor. A flag is raised whenever its source asks for service. The mask has no influence on that capture. A flag is lowered only when software writes a one into its bit position. Software therefore always sees the full set of sources that are waiting, and can find the ones that are actually enabled through a separate masked view.

Software reaches the block over a small register bus: a word address, a write strobe, write data, and combinational read data. The register window holds three words: pending, mask, and masked pending. Bit positions that carry no source are fixed at zero in the pending register. A parameter selects whether a source sets its flag on an asserted level or on a rising edge. The default is level.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset the pending register (word address 0x00) reads 0x00000000, the mask register (0x08) reads 0xFFFFFFFF, the masked view (0x10) reads 0, and `irq_out` is low.
- R2: A source bit seen high at a rising clock edge sets its pending flag at that edge, whether or not the mask bit for it is set.
- R3: A write to address 0x00 clears exactly the pending bits where the write data holds a one. Bits written with zero keep their value.
- R4: When a source sets a bit in the same cycle that a write to 0x00 clears that bit, the bit stays set.
- R5: Only source bits 1–7, 10, 11, 14, 17–22 and 27–29 exist (valid set 0x387E4CFE). All other pending bits read zero and are never set.
- R6: A write to address 0x08 loads the mask register on that clock edge. A one in a mask bit masks that source.
- R7: A read of address 0x10 returns the pending register ANDed with the inverted mask.
- R8: `irq_out` is high exactly when the masked pending value is nonzero, and it follows the pending and mask registers with no extra register stage.
- R9: A pending bit that has not been cleared raises `irq_out` as soon as its mask bit is written to zero.
- R10: Reads of any other address return zero, and writes to any other address change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 32 | Synchronised interrupt request lines, one per source position |
| bus_addr | input | 5 | Byte address of the register word |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt request to the processor |

## Verification
Both pending capture and register writes take effect at the rising edge on which the source or the write strobe is sampled. Because `irq_out` and read data come straight from the registers, every result is due one edge after its stimulus. Stimulus is therefore applied at a falling edge, and the outputs are checked at the next falling edge, after that single rising edge has passed. Read data is checked 1 ns after the address is driven, because it has no register of its own.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int unsigned IRQC_DATA_W   = 32;
   localparam int unsigned IRQC_ADDR_W   = 5;
   localparam logic [IRQC_ADDR_W-1:0] IRQC_OFS_PEND   = 5'h00;
   localparam logic [IRQC_ADDR_W-1:0] IRQC_OFS_MASK   = 5'h08;
   localparam logic [IRQC_ADDR_W-1:0] IRQC_OFS_ACTIVE = 5'h10;
   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_PEND   = 2'd1,
      SEL_MASK   = 2'd2,
      SEL_ACTIVE = 2'd3
   } irqc_sel_e;
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
   parameter int unsigned NUM_SRC  = 32,
   parameter bit          EDGE_SET = 1'b0,
   parameter logic [NUM_SRC-1:0] VALID = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src,
   output logic [NUM_SRC-1:0] set_v
);
   genvar gi;
   generate
      for (gi = 0; gi < NUM_SRC; gi++) begin : g_bit
         if (!VALID[gi]) begin : g_rsvd
            assign set_v[gi] = 1'b0;
         end else if (EDGE_SET) begin : g_edge
            logic src_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) src_q <= 1'b0;
               else        src_q <= src[gi];
            end
            assign set_v[gi] = src[gi] & ~src_q;
         end else begin : g_level
            assign set_v[gi] = src[gi];
         end
      end
   endgenerate
endmodule

// File: rtl/irqc_pend_reg.sv
module irqc_pend_reg #(
   parameter int unsigned NUM_SRC = 32,
   parameter logic [NUM_SRC-1:0] VALID = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_v,
   input  logic [NUM_SRC-1:0] clr_v,
   output logic [NUM_SRC-1:0] pend_q
);
   logic [NUM_SRC-1:0] pend_d;

   always_comb begin
      pend_d = ((pend_q & ~clr_v) | set_v) & VALID;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_d;
   end

   AST_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (|(set_v & VALID)) |=> ((pend_q & $past(set_v & VALID)) == $past(set_v & VALID))); // R4
   AST_CLEAR_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(pend_q) & ~pend_q) & ~$past(clr_v)) == '0)); // R3
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q & ~VALID) == '0); // R5
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
   parameter int unsigned NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [NUM_SRC-1:0] din,
   output logic [NUM_SRC-1:0] mask_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mask_q <= '1;
      else if (load) mask_q <= din;
   end

   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (mask_q == $past(din))); // R6
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(mask_q)); // R10
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 32,
   parameter bit          EDGE_SET = 1'b0,
   parameter logic [NUM_SRC-1:0] VALID = 32'h387E_4CFE
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_SRC-1:0]     src_in,
   input  logic [IRQC_ADDR_W-1:0] bus_addr,
   input  logic                   bus_we,
   input  logic [IRQC_DATA_W-1:0] bus_wdata,
   output logic [IRQC_DATA_W-1:0] bus_rdata,
   output logic                   irq_out
);
   localparam int unsigned PAD_W = IRQC_DATA_W - NUM_SRC;

   if (NUM_SRC < 1 || NUM_SRC > IRQC_DATA_W) begin : g_bad_width
      $error("irq_source_ctrl: NUM_SRC must lie in 1..32");
   end

   logic [NUM_SRC-1:0] set_v, clr_v, pend_q, mask_q, active_v;
   irqc_sel_e          sel;
   logic [NUM_SRC-1:0] rd_src;

   always_comb begin
      unique case (bus_addr)
         IRQC_OFS_PEND:   sel = SEL_PEND;
         IRQC_OFS_MASK:   sel = SEL_MASK;
         IRQC_OFS_ACTIVE: sel = SEL_ACTIVE;
         default:         sel = SEL_NONE;
      endcase
   end

   assign clr_v = (bus_we && sel == SEL_PEND) ? bus_wdata[NUM_SRC-1:0] : '0;

   irqc_capture #(.NUM_SRC(NUM_SRC), .EDGE_SET(EDGE_SET), .VALID(VALID)) u_cap (
      .clk(clk), .rst_n(rst_n), .src(src_in), .set_v(set_v)
   );

   irqc_pend_reg #(.NUM_SRC(NUM_SRC), .VALID(VALID)) u_pend (
      .clk(clk), .rst_n(rst_n), .set_v(set_v), .clr_v(clr_v), .pend_q(pend_q)
   );

   irqc_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
      .clk(clk), .rst_n(rst_n), .load(bus_we && sel == SEL_MASK),
      .din(bus_wdata[NUM_SRC-1:0]), .mask_q(mask_q)
   );

   assign active_v = pend_q & ~mask_q;
   assign irq_out  = |active_v;

   always_comb begin
      case (sel)
         SEL_PEND:   rd_src = pend_q;
         SEL_MASK:   rd_src = mask_q;
         SEL_ACTIVE: rd_src = active_v;
         default:    rd_src = '0;
      endcase
   end

   if (PAD_W > 0) begin : g_pad
      assign bus_rdata = {{PAD_W{1'b0}}, rd_src};
   end else begin : g_nopad
      assign bus_rdata = rd_src;
   end

   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out) |-> ($past(pend_q) != pend_q || $past(mask_q) != mask_q)); // R8
   AST_IRQ_RESET: assert property (@(posedge clk)
      $rose(rst_n) |-> !irq_out); // R1
endmodule

// File: tb/sim_irq_source_ctrl.sv
module sim_irq_source_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_in = '0;
   logic [4:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;
   int checks = 0;
   int fails = 0;
   localparam logic [31:0] VALID_SET = 32'h387E_4CFE;

   always #10 clk = ~clk;

   irq_source_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic pulse(input logic [31:0] v);
      @(negedge clk);
      src_in = v;
      @(negedge clk);
      src_in = '0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(5'h00, d); check("R1 pend", d, 32'h0);
      rd(5'h08, d); check("R1 mask", d, 32'hFFFF_FFFF);
      rd(5'h10, d); check("R1 active", d, 32'h0);
      check("R1 irq", {31'b0, irq_out}, 32'h0);
   endtask

   task automatic t_capture_masked();
      logic [31:0] d;
      pulse(32'h0000_0402);
      rd(5'h00, d); check("R2 pend while masked", d, 32'h0000_0402);
      rd(5'h10, d); check("R7 active while masked", d, 32'h0);
      check("R8 irq low while masked", {31'b0, irq_out}, 32'h0);
   endtask

   task automatic t_unmask();
      logic [31:0] d;
      wr(5'h08, ~32'h0000_0400);
      check("R9 irq after unmask", {31'b0, irq_out}, 32'h1);
      rd(5'h08, d); check("R6 mask readback", d, ~32'h0000_0400);
      rd(5'h10, d); check("R7 active view", d, 32'h0000_0400);
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      wr(5'h00, 32'h0000_0400);
      rd(5'h00, d); check("R3 partial clear", d, 32'h0000_0002);
      check("R8 irq drops", {31'b0, irq_out}, 32'h0);
      wr(5'h00, 32'h0000_0000);
      rd(5'h00, d); check("R3 zero write keeps", d, 32'h0000_0002);
   endtask

   task automatic t_reserved();
      logic [31:0] d;
      pulse(32'hFFFF_FFFF);
      rd(5'h00, d); check("R5 valid bits only", d, VALID_SET);
      wr(5'h00, 32'hFFFF_FFFF);
      rd(5'h00, d); check("R3 clear all", d, 32'h0);
   endtask

   task automatic t_set_wins();
      logic [31:0] d;
      @(negedge clk);
      src_in = 32'h0000_0800;
      bus_addr = 5'h00; bus_we = 1'b1; bus_wdata = 32'h0000_0800;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0; src_in = '0;
      rd(5'h00, d); check("R4 set beats clear", d, 32'h0000_0800);
      wr(5'h00, 32'h0000_0800);
      rd(5'h00, d); check("R4 later clear", d, 32'h0);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      pulse(32'h0800_0000);
      wr(5'h04, 32'hFFFF_FFFF);
      wr(5'h0C, 32'h0000_0000);
      rd(5'h04, d); check("R10 read unmapped", d, 32'h0);
      rd(5'h00, d); check("R10 pend unchanged", d, 32'h0800_0000);
      rd(5'h08, d); check("R10 mask unchanged", d, ~32'h0000_0400);
      check("R9 masked pend no irq", {31'b0, irq_out}, 32'h0);
      wr(5'h08, 32'h0);
      check("R9 uncleared pend re-raises", {31'b0, irq_out}, 32'h1);
   endtask

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_capture_masked();
      t_unmask();
      t_w1c();
      t_reserved();
      t_set_wins();
      t_unmapped();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule